// File: doc/BRIEF.md
# Keyboard and Display Terminal Port

This block sits on the bus of an 8-bit processor and gives it a minimal terminal: a keyboard input with a one-entry holding buffer, and a character output stream toward a display. The processor polls a status address to learn whether a key is waiting, then reads the key from a data address, which also frees the buffer for the next keystroke. Keystrokes arrive as 8-bit codes with a valid strobe and are normalised on the way in: line feed becomes carriage return, delete and backspace both become underscore, and lowercase letters fold to uppercase. Two control codes are not buffered at all; instead they fire one-cycle reset and break request pulses for the surrounding system.

On the output side, a byte written to the display address is trimmed to seven bits and normalised: delete is shown as an at-sign and carriage return goes out as line feed. An underscore is treated as a rubout and expands into backspace, space, backspace. Bytes leave through a valid/ready handshake. While any output byte or rubout sequence is still outstanding the port reports busy and drops further display writes.

Addresses, data width and the two translation options are parameters. Bus reads are combinational; every other output is registered.

Top module: `kbd_disp_port`

## Requirements
- R1: A read of the status address (default 0xD011) returns 0x80 while a key is held and 0x00 when none is held.
- R2: A read of the key address (default 0xD010) while a key is held returns the stored code with bit 7 set and empties the buffer at that clock edge; with no key held the same read returns 0x00 and changes nothing.
- R3: A key strobe is taken only when the buffer is empty; a strobe arriving while a key is held is dropped and the held key is kept unchanged.
- R4: Input translation: 0x0A is stored as 0x0D, 0x7F and 0x08 are stored as 0x5F, 0x61 through 0x7A have bit 5 cleared, all other codes are stored as received.
- R5: Input code 0x12 produces a one-cycle pulse on reset_req and input code 0x02 a one-cycle pulse on break_req, each in the cycle after the strobe; neither code is stored as a key.
- R6: A write to the display address (default 0xD012) clears bit 7 of the byte; after that 0x7F is sent as 0x40, 0x0D is sent as 0x0A, and any other value except 0x5F is sent unchanged, with disp_valid high from the cycle after the write.
- R7: A display write whose low 7 bits equal 0x5F sends the three bytes 0x08, 0x20, 0x08 in that order, one per completed handshake.
- R8: While disp_valid is high and disp_ready is low, disp_valid stays high and disp_data stays unchanged.
- R9: disp_busy is high whenever output is outstanding, and display writes made while it is high are dropped.
- R10: Reads of any other address, and bus_rdata whenever bus_rd is low, return 0x00.
- R11: Synchronous active-high reset empties the key buffer, clears both request pulses and drops any outstanding display output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| key_valid | input | 1 | Keystroke strobe |
| key_code | input | 8 | Raw keystroke code |
| reset_req | output | 1 | One-cycle reset request |
| break_req | output | 1 | One-cycle break request |
| disp_valid | output | 1 | Output byte available |
| disp_data | output | 8 | Output byte |
| disp_ready | input | 1 | Consumer takes the byte |
| disp_busy | output | 1 | Output outstanding, display writes dropped |

## Verification
Keystrokes cover every translated class (line feed, both erase codes, both ends of the lowercase range, characters just outside it, plain characters) so a wrong range bound or missing mapping shows as a different stored code. A second key sent while the first is unread distinguishes a buffer that overwrites from one that holds. Display writes include bytes with bit 7 set, delete, carriage return, and the rubout in both its plain and bit-7 forms; the rubout is drained with stalls between bytes so that order, hold under back-pressure and the dropping of a write issued mid-sequence are each seen separately.

// File: rtl/kdp_pkg.sv
package kdp_pkg;

   localparam int BYTE_W    = 8;
   localparam int RUBOUT_LEN = 3;

   localparam logic [7:0] C_LF    = 8'h0A;
   localparam logic [7:0] C_CR    = 8'h0D;
   localparam logic [7:0] C_DEL   = 8'h7F;
   localparam logic [7:0] C_BS    = 8'h08;
   localparam logic [7:0] C_SPACE = 8'h20;
   localparam logic [7:0] C_AT    = 8'h40;
   localparam logic [7:0] C_UNDER = 8'h5F;
   localparam logic [7:0] C_RSTK  = 8'h12;
   localparam logic [7:0] C_BRKK  = 8'h02;

   typedef enum logic [1:0] {
      KC_PLAIN = 2'd0,
      KC_RESET = 2'd1,
      KC_BREAK = 2'd2
   } key_class_e;

   function automatic key_class_e classify_key(input logic [7:0] code);
      if (code == C_RSTK)      return KC_RESET;
      else if (code == C_BRKK) return KC_BREAK;
      else                     return KC_PLAIN;
   endfunction

   function automatic logic [7:0] fold_key(input logic [7:0] code, input logic fold_case);
      logic [7:0] r;
      r = code;
      if (code == C_LF)                         r = C_CR;
      else if (code == C_DEL || code == C_BS)   r = C_UNDER;
      else if (fold_case && code >= 8'h61 && code <= 8'h7A) r = code & 8'hDF;
      return r;
   endfunction

   function automatic logic [7:0] map_display(input logic [6:0] ch);
      logic [7:0] r;
      r = {1'b0, ch};
      if (r == C_DEL)     r = C_AT;
      else if (r == C_CR) r = C_LF;
      return r;
   endfunction

   function automatic logic [7:0] rubout_byte(input logic [1:0] idx);
      case (idx)
         2'd1:    return C_SPACE;
         default: return C_BS;
      endcase
   endfunction

endpackage

// File: rtl/kdp_key_in.sv
module kdp_key_in
   import kdp_pkg::*;
#(
   parameter bit FOLD_CASE = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       key_valid,
   input  logic [7:0] key_code,
   input  logic       take,
   output logic       pending,
   output logic [7:0] held_code,
   output logic       reset_pulse,
   output logic       break_pulse
);

   logic [7:0] xlat_code;
   key_class_e kclass;
   logic       arrive;

   generate
      if (FOLD_CASE) begin : g_fold
         assign xlat_code = fold_key(key_code, 1'b1);
      end else begin : g_nofold
         assign xlat_code = fold_key(key_code, 1'b0);
      end
   endgenerate

   assign kclass = classify_key(key_code);
   assign arrive = key_valid && !pending;

   always_ff @(posedge clk) begin
      if (rst) begin
         pending     <= 1'b0;
         held_code   <= '0;
         reset_pulse <= 1'b0;
         break_pulse <= 1'b0;
      end else begin
         reset_pulse <= arrive && (kclass == KC_RESET);
         break_pulse <= arrive && (kclass == KC_BREAK);
         if (arrive && kclass == KC_PLAIN) begin
            pending   <= 1'b1;
            held_code <= xlat_code;
         end else if (take) begin
            pending <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/kdp_disp_out.sv
module kdp_disp_out
   import kdp_pkg::*;
#(
   parameter bit EXPAND_RUBOUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_stb,
   input  logic [6:0] wr_char,
   input  logic       out_ready,
   output logic       out_valid,
   output logic [7:0] out_data
);

   localparam logic [1:0] LAST_IDX = 2'(RUBOUT_LEN - 1);

   logic       in_rubout;
   logic [1:0] seq_idx;
   logic       is_rubout;
   logic       load;
   logic       handoff;

   generate
      if (EXPAND_RUBOUT) begin : g_expand
         assign is_rubout = ({1'b0, wr_char} == C_UNDER);
      end else begin : g_plain
         assign is_rubout = 1'b0;
      end
   endgenerate

   assign load    = wr_stb && !out_valid;
   assign handoff = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         in_rubout <= 1'b0;
         seq_idx   <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         in_rubout <= is_rubout;
         seq_idx   <= '0;
         out_data  <= is_rubout ? rubout_byte(2'd0) : map_display(wr_char);
      end else if (handoff) begin
         if (in_rubout && seq_idx != LAST_IDX) begin
            seq_idx  <= seq_idx + 2'd1;
            out_data <= rubout_byte(seq_idx + 2'd1);
         end else begin
            out_valid <= 1'b0;
            in_rubout <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/kdp_bus_dec.sv
module kdp_bus_dec #(
   parameter int               ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 16'hD010,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hD011,
   parameter logic [ADDR_W-1:0] DISP_ADDR = 16'hD012
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              pending,
   input  logic [7:0]        held_code,
   output logic [7:0]        rdata,
   output logic              take,
   output logic              disp_wr
);

   logic hit_key, hit_stat, hit_disp;

   assign hit_key  = (addr == KEY_ADDR);
   assign hit_stat = (addr == STAT_ADDR);
   assign hit_disp = (addr == DISP_ADDR);

   assign take    = rd && hit_key && pending;
   assign disp_wr = wr && hit_disp;

   always_comb begin
      rdata = '0;
      if (rd && hit_stat)                rdata = {pending, 7'd0};
      else if (rd && hit_key && pending) rdata = {1'b1, held_code[6:0]};
   end

endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
   import kdp_pkg::*;
#(
   parameter int                ADDR_W        = 16,
   parameter int                DATA_W        = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR      = 16'hD010,
   parameter logic [ADDR_W-1:0] STAT_ADDR     = 16'hD011,
   parameter logic [ADDR_W-1:0] DISP_ADDR     = 16'hD012,
   parameter bit                FOLD_CASE     = 1'b1,
   parameter bit                EXPAND_RUBOUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              key_valid,
   input  logic [DATA_W-1:0] key_code,
   output logic              reset_req,
   output logic              break_req,
   output logic              disp_valid,
   output logic [DATA_W-1:0] disp_data,
   input  logic              disp_ready,
   output logic              disp_busy
);

   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("kbd_disp_port: DATA_W must be 8");
      end
      if (KEY_ADDR == STAT_ADDR || KEY_ADDR == DISP_ADDR || STAT_ADDR == DISP_ADDR) begin : g_bad_map
         $error("kbd_disp_port: register addresses must differ");
      end
   endgenerate

   logic       key_pending;
   logic [7:0] key_q;
   logic       key_take;
   logic       disp_wr;

   kdp_key_in #(.FOLD_CASE(FOLD_CASE)) u_key (
      .clk         (clk),
      .rst         (rst),
      .key_valid   (key_valid),
      .key_code    (key_code),
      .take        (key_take),
      .pending     (key_pending),
      .held_code   (key_q),
      .reset_pulse (reset_req),
      .break_pulse (break_req)
   );

   kdp_bus_dec #(
      .ADDR_W    (ADDR_W),
      .KEY_ADDR  (KEY_ADDR),
      .STAT_ADDR (STAT_ADDR),
      .DISP_ADDR (DISP_ADDR)
   ) u_dec (
      .addr      (bus_addr),
      .rd        (bus_rd),
      .wr        (bus_wr),
      .pending   (key_pending),
      .held_code (key_q),
      .rdata     (bus_rdata),
      .take      (key_take),
      .disp_wr   (disp_wr)
   );

   kdp_disp_out #(.EXPAND_RUBOUT(EXPAND_RUBOUT)) u_disp (
      .clk       (clk),
      .rst       (rst),
      .wr_stb    (disp_wr),
      .wr_char   (bus_wdata[6:0]),
      .out_ready (disp_ready),
      .out_valid (disp_valid),
      .out_data  (disp_data)
   );

   assign disp_busy = disp_valid;

endmodule

// File: rtl/kdp_checker.sv
module kdp_checker #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 16'hD010,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hD011
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic [7:0]        bus_rdata,
   input logic              key_valid,
   input logic [7:0]        key_code,
   input logic              reset_req,
   input logic              break_req,
   input logic              disp_valid,
   input logic [7:0]        disp_data,
   input logic              disp_ready,
   input logic              key_pending,
   input logic [7:0]        key_q
);

   a_r1_status_values: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == STAT_ADDR) |-> (bus_rdata == 8'h80 || bus_rdata == 8'h00));

   a_r2_read_empties: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == KEY_ADDR && bus_rdata[7]) |=> !key_pending);

   a_r3_held_key_kept: assert property (@(posedge clk) disable iff (rst)
      (key_pending && !(bus_rd && bus_addr == KEY_ADDR)) |=> (key_pending && $stable(key_q)));

   a_r5_reset_cause: assert property (@(posedge clk) disable iff (rst)
      reset_req |-> $past(key_valid && key_code == 8'h12));

   a_r5_break_cause: assert property (@(posedge clk) disable iff (rst)
      break_req |-> $past(key_valid && key_code == 8'h02));

   a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
      $onehot0({reset_req, break_req}));

   a_r6_seven_bit: assert property (@(posedge clk) disable iff (rst)
      disp_valid |-> !disp_data[7]);

   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_data)));

endmodule

bind kbd_disp_port kdp_checker #(
   .ADDR_W    (ADDR_W),
   .KEY_ADDR  (KEY_ADDR),
   .STAT_ADDR (STAT_ADDR)
) u_kdp_checker (
   .clk         (clk),
   .rst         (rst),
   .bus_addr    (bus_addr),
   .bus_rd      (bus_rd),
   .bus_rdata   (bus_rdata),
   .key_valid   (key_valid),
   .key_code    (key_code),
   .reset_req   (reset_req),
   .break_req   (break_req),
   .disp_valid  (disp_valid),
   .disp_data   (disp_data),
   .disp_ready  (disp_ready),
   .key_pending (key_pending),
   .key_q       (key_q)
);

// File: tb/kbd_disp_port_bench.sv
`timescale 1ns/1ps
module kbd_disp_port_bench;

   localparam logic [15:0] A_KEY  = 16'hD010;
   localparam logic [15:0] A_STAT = 16'hD011;
   localparam logic [15:0] A_DISP = 16'hD012;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        key_valid = 1'b0;
   logic [7:0]  key_code = '0;
   logic        reset_req, break_req;
   logic        disp_valid;
   logic [7:0]  disp_data;
   logic        disp_ready = 1'b0;
   logic        disp_busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   kbd_disp_port u_kbd_disp_port (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_valid(key_valid),
      .key_code(key_code), .reset_req(reset_req), .break_req(break_req),
      .disp_valid(disp_valid), .disp_data(disp_data), .disp_ready(disp_ready),
      .disp_busy(disp_busy)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic send_key(input logic [7:0] c);
      @(negedge clk); key_valid = 1'b1; key_code = c;
      @(negedge clk); key_valid = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #0.5 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic take_byte(input string req, input logic [7:0] exp);
      chk({req, " valid"}, {7'd0, disp_valid}, 8'h01);
      chk(req, disp_data, exp);
      disp_ready = 1'b1;
      @(negedge clk); disp_ready = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk("R11 valid", {7'd0, disp_valid}, 8'h00);
      chk("R11 reqs", {6'd0, reset_req, break_req}, 8'h00);
      bus_read(A_STAT, d); chk("R11 status", d, 8'h00);
   endtask

   task automatic t_key_path;
      logic [7:0] d;
      bus_read(A_KEY, d); chk("R2 empty read", d, 8'h00);
      bus_read(A_STAT, d); chk("R2 empty no effect", d, 8'h00);
      send_key(8'h41);
      bus_read(A_STAT, d); chk("R1 status pending", d, 8'h80);
      send_key(8'h42);
      bus_read(A_KEY, d); chk("R3 first key kept", d, 8'hC1);
      bus_read(A_STAT, d); chk("R2 cleared", d, 8'h00);
      bus_read(A_KEY, d); chk("R2 second read", d, 8'h00);
   endtask

   task automatic key_xlat(input logic [7:0] in, input logic [7:0] exp);
      logic [7:0] d;
      send_key(in);
      bus_read(A_KEY, d); chk("R4 translate", d, exp | 8'h80);
   endtask

   task automatic t_translate;
      key_xlat(8'h0A, 8'h0D);
      key_xlat(8'h7F, 8'h5F);
      key_xlat(8'h08, 8'h5F);
      key_xlat(8'h61, 8'h41);
      key_xlat(8'h7A, 8'h5A);
      key_xlat(8'h60, 8'h60);
      key_xlat(8'h7B, 8'h7B);
      key_xlat(8'h33, 8'h33);
   endtask

   task automatic t_control;
      logic [7:0] d;
      @(negedge clk); key_valid = 1'b1; key_code = 8'h12;
      @(negedge clk); key_valid = 1'b0;
      chk("R5 reset pulse", {6'd0, reset_req, break_req}, 8'h02);
      @(negedge clk);
      chk("R5 reset single", {6'd0, reset_req, break_req}, 8'h00);
      @(negedge clk); key_valid = 1'b1; key_code = 8'h02;
      @(negedge clk); key_valid = 1'b0;
      chk("R5 break pulse", {6'd0, reset_req, break_req}, 8'h01);
      bus_read(A_STAT, d); chk("R5 not latched", d, 8'h00);
   endtask

   task automatic t_display;
      bus_write(A_DISP, 8'hC8);
      chk("R9 busy", {7'd0, disp_busy}, 8'h01);
      take_byte("R6 mask", 8'h48);
      bus_write(A_DISP, 8'h7F); take_byte("R6 del", 8'h40);
      bus_write(A_DISP, 8'h0D); take_byte("R6 cr", 8'h0A);
      bus_write(A_DISP, 8'h5E); take_byte("R6 plain", 8'h5E);
      chk("R9 idle", {7'd0, disp_busy}, 8'h00);
   endtask

   task automatic t_rubout;
      bus_write(A_DISP, 8'hDF);
      repeat (3) @(negedge clk);
      chk("R8 hold data", disp_data, 8'h08);
      bus_write(A_DISP, 8'h41);
      take_byte("R7 byte0", 8'h08);
      @(negedge clk);
      take_byte("R7 byte1", 8'h20);
      take_byte("R7 byte2", 8'h08);
      chk("R9 dropped write", {7'd0, disp_valid}, 8'h00);
   endtask

   task automatic t_other;
      logic [7:0] d;
      send_key(8'h44);
      bus_read(16'hD013, d); chk("R10 other addr", d, 8'h00);
      bus_read(16'h0011, d); chk("R10 alias", d, 8'h00);
      chk("R10 idle rdata", bus_rdata, 8'h00);
      bus_write(A_DISP, 8'h5F);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R11 drop output", {7'd0, disp_valid}, 8'h00);
      bus_read(A_STAT, d); chk("R11 empty", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset;
      t_key_path;
      t_translate;
      t_control;
      t_display;
      t_rubout;
      t_other;
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule